// File: doc/BRIEF.md
# Packet Command Decoder with Banked Register Storage

This block turns a framed byte stream into parameter updates for a solenoid driver's hold-PWM generator and its attack/hold sequencer. A packet opens with a start marker and closes with a stop marker. The first byte after the start is the opcode and the bytes after it are arguments. Most commands take effect in the cycle after the stop marker. The write-memory command is the exception: it stores each value byte as it arrives, so a single packet can carry a burst of any length.

The block holds three byte banks. Bank 0 is a 20-entry register file that also holds the block's own pointers and parameters. Bank 1 is a 128-entry velocity table. Bank 2 is a 256-entry RAM that stands in for nonvolatile storage. Each bank has its own read pointer and its own write pointer, and both advance on every access. A read stream returns bytes from the selected bank at that bank's read pointer.

Stream rules:
- Input bytes are accepted when `in_valid && in_ready`. `in_ready` drops in any cycle where `in_stop` is high and for as long as a table copy runs.
- The read stream presents `rd_data` whenever `rd_valid` is high. A transfer happens when `rd_valid && rd_ready`. `rd_valid` is low only while a copy runs.
- The consumer may hold `rd_ready` low for as long as it likes without losing data. The pointer does not move until the transfer.

Top module: `pcr_top`

## Requirements
- R1: After reset, duty is 127, top is 255 and divider is 5. The hold delay, flags, error status and busy flag are 0. The read source is bank 0 and every pointer is 0.
- R2: Opcode 0 takes the duty, then an optional top, then an optional divider. When at least the duty is given, any omitted top becomes 255 and any omitted divider becomes 5. With no arguments nothing changes.
- R3: Opcode 1 with a velocity byte v pulses `note_on` for one cycle and sets `attack_ticks` to `{8'h00, table[v[6:0]]}`. Opcode 2 with bytes hi and lo pulses `note_on` and sets `attack_ticks` to `{hi, lo}`.
- R4: Opcode 3 pulses `note_off` for one cycle. `note_on` and `note_off` never pulse together.
- R5: Opcode 4 takes a source byte s (0 register file, 1 velocity table, 2 RAM) and an optional address. The address, when present, loads bank s's read pointer. Each read transfer returns the byte at that pointer and then adds one to that bank's pointer.
- R6: Opcode 5's first argument selects the bank with bits 1:0 (same ids as R5). Its bit 7 says whether the next byte is an address that loads the bank's write pointer. Every following byte is written at the write pointer, which then adds one.
- R7: Opcode 7 sets `hold_delay`. Two bytes give `{hi, lo}`, one byte gives `{hi, 8'h00}` and no bytes give 0.
- R8: Opcode 8 stores a flags byte. Bit 0 drives `hold_at_attack`.
- R9: An opcode above 8 sets error bit 0 and its packet is ignored. Bank id 3 sets error bit 1, both as an opcode 4 source and in an opcode 5 first argument, and that command is ignored. Error bits stay set until register 15 is rewritten through opcode 5.
- R10: Opcode 6 raises `copy_busy` for exactly 128 cycles, starting the cycle after the stop marker, and holds `in_ready` and `rd_valid` low while it is high. Afterwards RAM entries 0..127 equal the velocity table entries.
- R11: Bytes outside a packet are ignored. A new start marker abandons an unfinished packet without executing it.
- R12: If a read transfer falls in the same cycle as an opcode 4 that loads an address, the transfer returns the byte at the old pointer and the loaded address replaces the increment.
- R13: Register file reads return stored state: address 11 holds the duty and address 12 holds the top. Addresses 20..255 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_start | input | 1 | Packet start marker |
| in_stop | input | 1 | Packet stop marker |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read transfer when high with rd_valid |
| rd_data | output | 8 | Byte at the selected bank's read pointer |
| pwm_duty | output | 8 | Hold PWM duty |
| pwm_top | output | 8 | Hold PWM counter top |
| pwm_div | output | 8 | Hold PWM clock divider select |
| hold_delay | output | 16 | Ticks between attack end and hold |
| hold_at_attack | output | 1 | Apply hold at attack start |
| note_on | output | 1 | One-cycle note onset pulse |
| note_off | output | 1 | One-cycle note release pulse |
| attack_ticks | output | 16 | Attack pulse length in ticks |
| copy_busy | output | 1 | Table copy in progress |
| err_status | output | 8 | Sticky error bits |

## Verification
Two functions can fall in the same cycle: a read transfer, which advances a bank's read pointer, and an opcode 4 command that reloads that same pointer. The bench provokes this by driving `rd_ready` in the very cycle that carries the stop marker of an opcode 4 packet. The pointer starts at one address and the reload names the one just below it, so the two possible winners produce different results. The captured byte must come from the old pointer, and the next read must come from the reloaded address; if the increment had won, that read would return a different byte.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam logic [3:0] OP_PWM   = 4'd0;
  localparam logic [3:0] OP_VEL   = 4'd1;
  localparam logic [3:0] OP_TICKS = 4'd2;
  localparam logic [3:0] OP_OFF   = 4'd3;
  localparam logic [3:0] OP_RSRC  = 4'd4;
  localparam logic [3:0] OP_WMEM  = 4'd5;
  localparam logic [3:0] OP_COPY  = 4'd6;
  localparam logic [3:0] OP_DELAY = 4'd7;
  localparam logic [3:0] OP_FLAGS = 4'd8;
  localparam logic [7:0] OP_LAST  = 8'd8;

  localparam int RA_RPTR   = 0;
  localparam int RA_RSRC   = 3;
  localparam int RA_WPTR   = 4;
  localparam int RA_WDST   = 7;
  localparam int RA_TK_HI  = 8;
  localparam int RA_TK_LO  = 9;
  localparam int RA_TDIV   = 10;
  localparam int RA_DUTY   = 11;
  localparam int RA_TOP    = 12;
  localparam int RA_DIV    = 13;
  localparam int RA_STATE  = 14;
  localparam int RA_ERR    = 15;
  localparam int RA_MAXHI  = 16;
  localparam int RA_DLY_HI = 17;
  localparam int RA_DLY_LO = 18;
  localparam int RA_FLAGS  = 19;

  localparam logic [7:0] DEF_DUTY = 8'd127;
  localparam logic [7:0] DEF_TOP  = 8'd255;
  localparam logic [7:0] DEF_DIV  = 8'd5;

  typedef enum logic [1:0] {P_IDLE, P_OPC, P_ARG, P_SKIP} pst_t;

  function automatic logic [7:0] rf_reset_val(int a);
    case (a)
      RA_DUTY:  return DEF_DUTY;
      RA_TOP:   return DEF_TOP;
      RA_DIV:   return DEF_DIV;
      RA_TDIV:  return 8'd4;
      RA_MAXHI: return 8'hFF;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pcr_parser.sv
module pcr_parser
  import pcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_start,
  input  logic       in_stop,
  output logic       exec_vld,
  output logic [3:0] exec_op,
  output logic [1:0] exec_argc,
  output logic [7:0] exec_a0,
  output logic [7:0] exec_a1,
  output logic [7:0] exec_a2,
  output logic       mw_dst_vld,
  output logic       mw_addr_vld,
  output logic       mw_data_vld,
  output logic       err_opc,
  output logic       err_bank
);
  pst_t st, eff_st;
  logic fire, is_mw, first_arg, need_addr;

  assign in_ready  = !busy && !in_stop;
  assign fire      = in_valid && in_ready;
  assign eff_st    = in_start ? P_OPC : st;
  assign is_mw     = (eff_st == P_ARG) && (exec_op == OP_WMEM);
  assign first_arg = (exec_argc == 2'd0);

  assign exec_vld    = in_stop && (st == P_ARG);
  assign err_opc     = fire && (eff_st == P_OPC) && (in_data > OP_LAST);
  assign mw_dst_vld  = fire && is_mw && first_arg && (in_data[1:0] != 2'd3);
  assign err_bank    = fire && is_mw && first_arg && (in_data[1:0] == 2'd3);
  assign mw_addr_vld = fire && is_mw && !first_arg && need_addr;
  assign mw_data_vld = fire && is_mw && !first_arg && !need_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= P_IDLE;
      exec_op   <= '0;
      exec_argc <= '0;
      exec_a0   <= '0;
      exec_a1   <= '0;
      exec_a2   <= '0;
      need_addr <= 1'b0;
    end else begin
      if (in_stop) st <= P_IDLE;
      if (fire) begin
        case (eff_st)
          P_OPC: begin
            exec_op   <= in_data[3:0];
            exec_argc <= '0;
            st        <= (in_data > OP_LAST) ? P_SKIP : P_ARG;
          end
          P_ARG: begin
            if (exec_argc != 2'd3) exec_argc <= exec_argc + 2'd1;
            case (exec_argc)
              2'd0:    exec_a0 <= in_data;
              2'd1:    exec_a1 <= in_data;
              2'd2:    exec_a2 <= in_data;
              default: ;
            endcase
            if (is_mw && first_arg) begin
              need_addr <= in_data[7];
              if (in_data[1:0] == 2'd3) st <= P_SKIP;
            end else if (is_mw && need_addr) begin
              need_addr <= 1'b0;
            end
          end
          default: ;
        endcase
      end else if (in_start) begin
        st        <= P_OPC;
        exec_argc <= '0;
      end
    end
  end

  // R11: one decoded action per cycle
  assert_one_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exec_vld, mw_dst_vld, mw_addr_vld, mw_data_vld}));
  // R10: no byte taken while a copy runs
  assert_no_byte_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(mw_data_vld || mw_addr_vld || mw_dst_vld || err_opc));
endmodule

// File: rtl/pcr_copy.sv
module pcr_copy #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == LAST) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end
  end

  // R10: walk advances by one entry per cycle
  assert_copy_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> idx == $past(idx) + 1'b1);
  // R10: a copy is never requested while one runs
  assert_copy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/pcr_store.sv
module pcr_store
  import pcr_pkg::*;
#(
  parameter int RF_N  = 20,
  parameter int TBL_N = 128,
  parameter int NV_N  = 256,
  localparam int RF_AW  = $clog2(RF_N),
  localparam int TBL_AW = $clog2(TBL_N),
  localparam int NV_AW  = $clog2(NV_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_vld,
  input  logic [3:0]        exec_op,
  input  logic [1:0]        exec_argc,
  input  logic [7:0]        exec_a0,
  input  logic [7:0]        exec_a1,
  input  logic [7:0]        exec_a2,
  input  logic              mw_dst_vld,
  input  logic              mw_addr_vld,
  input  logic              mw_data_vld,
  input  logic [7:0]        mw_byte,
  input  logic              err_opc,
  input  logic              err_bank,
  input  logic              rd_fire,
  output logic [7:0]        rd_data,
  input  logic              cp_busy,
  input  logic [TBL_AW-1:0] cp_idx,
  output logic              cp_start,
  output logic [7:0]        pwm_duty,
  output logic [7:0]        pwm_top,
  output logic [7:0]        pwm_div,
  output logic [15:0]       hold_delay,
  output logic              hold_at_attack,
  output logic              note_on,
  output logic              note_off,
  output logic [15:0]       attack_ticks,
  output logic [7:0]        err_status
);
  localparam logic [7:0]       RF_LIM  = 8'(RF_N);
  localparam logic [RF_AW-1:0] WP_BASE = RF_AW'(RA_WPTR);

  logic [7:0] rf  [RF_N];
  logic [7:0] vel [TBL_N];
  logic [7:0] nv  [NV_N];

  logic [1:0]       rsel, wsel;
  logic [RF_AW-1:0] rp_idx, wp_idx;
  logic [7:0]       rptr, wptr;

  assign rsel   = rf[RA_RSRC][1:0];
  assign wsel   = rf[RA_WDST][1:0];
  assign rp_idx = {{(RF_AW-2){1'b0}}, rsel};
  assign wp_idx = WP_BASE + {{(RF_AW-2){1'b0}}, wsel};
  assign rptr   = rf[rp_idx];
  assign wptr   = rf[wp_idx];
  assign cp_start = exec_vld && (exec_op == OP_COPY);

  always_comb begin
    rd_data = 8'h00;
    case (rf[RA_RSRC])
      8'd0: if (rptr < RF_LIM) rd_data = rf[rptr[RF_AW-1:0]];
      8'd1: rd_data = vel[rptr[TBL_AW-1:0]];
      8'd2: rd_data = nv[rptr[NV_AW-1:0]];
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RF_N; i++)  rf[i]  <= rf_reset_val(i);
      for (int i = 0; i < TBL_N; i++) vel[i] <= 8'h00;
      for (int i = 0; i < NV_N; i++)  nv[i]  <= 8'h00;
      note_on  <= 1'b0;
      note_off <= 1'b0;
    end else begin
      note_on  <= 1'b0;
      note_off <= 1'b0;
      if (rd_fire && rf[RA_RSRC] < 8'd3) rf[rp_idx] <= rptr + 8'd1;
      if (cp_busy) nv[NV_AW'(cp_idx)] <= vel[cp_idx];
      if (mw_dst_vld) rf[RA_WDST] <= {6'd0, mw_byte[1:0]};
      if (mw_addr_vld) rf[wp_idx] <= mw_byte;
      if (mw_data_vld) begin
        case (wsel)
          2'd0: if (wptr < RF_LIM) rf[wptr[RF_AW-1:0]] <= mw_byte;
          2'd1: vel[wptr[TBL_AW-1:0]] <= mw_byte;
          default: nv[wptr[NV_AW-1:0]] <= mw_byte;
        endcase
        rf[wp_idx] <= wptr + 8'd1;
      end
      if (err_opc)  rf[RA_ERR][0] <= 1'b1;
      if (err_bank) rf[RA_ERR][1] <= 1'b1;
      if (exec_vld) begin
        case (exec_op)
          OP_PWM: if (exec_argc != 2'd0) begin
            rf[RA_DUTY] <= exec_a0;
            rf[RA_TOP]  <= (exec_argc >= 2'd2) ? exec_a1 : DEF_TOP;
            rf[RA_DIV]  <= (exec_argc == 2'd3) ? exec_a2 : DEF_DIV;
          end
          OP_VEL: if (exec_argc != 2'd0) begin
            rf[RA_TK_HI] <= 8'h00;
            rf[RA_TK_LO] <= vel[exec_a0[TBL_AW-1:0]];
            rf[RA_STATE] <= 8'd1;
            note_on      <= 1'b1;
          end
          OP_TICKS: if (exec_argc >= 2'd2) begin
            rf[RA_TK_HI] <= exec_a0;
            rf[RA_TK_LO] <= exec_a1;
            rf[RA_STATE] <= 8'd1;
            note_on      <= 1'b1;
          end
          OP_OFF: begin
            rf[RA_STATE] <= 8'd0;
            note_off     <= 1'b1;
          end
          OP_RSRC: if (exec_argc != 2'd0) begin
            if (exec_a0 > 8'd2) begin
              rf[RA_ERR][1] <= 1'b1;
            end else begin
              rf[RA_RSRC] <= exec_a0;
              if (exec_argc >= 2'd2)
                rf[{{(RF_AW-2){1'b0}}, exec_a0[1:0]}] <= exec_a1;
            end
          end
          OP_DELAY: begin
            rf[RA_DLY_HI] <= (exec_argc != 2'd0) ? exec_a0 : 8'h00;
            rf[RA_DLY_LO] <= (exec_argc >= 2'd2) ? exec_a1 : 8'h00;
          end
          OP_FLAGS: if (exec_argc != 2'd0) rf[RA_FLAGS] <= exec_a0;
          default: ;
        endcase
      end
    end
  end

  assign pwm_duty       = rf[RA_DUTY];
  assign pwm_top        = rf[RA_TOP];
  assign pwm_div        = rf[RA_DIV];
  assign hold_delay     = {rf[RA_DLY_HI], rf[RA_DLY_LO]};
  assign hold_at_attack = rf[RA_FLAGS][0];
  assign attack_ticks   = {rf[RA_TK_HI], rf[RA_TK_LO]};
  assign err_status     = rf[RA_ERR];

  // R4: onset and release never pulse together
  assert_note_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(note_on && note_off));
  // R9: error bit 0 stays set unless bank-0 data is written
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rf[RA_ERR][0] && !mw_data_vld |=> rf[RA_ERR][0]);
  // R3: a note onset pulse lasts one cycle
  assert_onset_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    note_on && !exec_vld |=> !note_on);
endmodule

// File: rtl/pcr_top.sv
module pcr_top
  import pcr_pkg::*;
#(
  parameter int RF_N  = 20,
  parameter int TBL_N = 128,
  parameter int NV_N  = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_start,
  input  logic        in_stop,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [7:0]  rd_data,
  output logic [7:0]  pwm_duty,
  output logic [7:0]  pwm_top,
  output logic [7:0]  pwm_div,
  output logic [15:0] hold_delay,
  output logic        hold_at_attack,
  output logic        note_on,
  output logic        note_off,
  output logic [15:0] attack_ticks,
  output logic        copy_busy,
  output logic [7:0]  err_status
);
  localparam int TBL_AW = $clog2(TBL_N);

  logic              exec_vld, mw_dst_vld, mw_addr_vld, mw_data_vld;
  logic              err_opc, err_bank, cp_start, rd_fire;
  logic [3:0]        exec_op;
  logic [1:0]        exec_argc;
  logic [7:0]        exec_a0, exec_a1, exec_a2;
  logic [TBL_AW-1:0] cp_idx;

  assign rd_valid = !copy_busy;
  assign rd_fire  = rd_valid && rd_ready;

  pcr_parser u_parser (
    .clk, .rst_n, .busy(copy_busy), .in_valid, .in_ready, .in_data,
    .in_start, .in_stop, .exec_vld, .exec_op, .exec_argc, .exec_a0,
    .exec_a1, .exec_a2, .mw_dst_vld, .mw_addr_vld, .mw_data_vld,
    .err_opc, .err_bank
  );

  pcr_copy #(.DEPTH(TBL_N)) u_copy (
    .clk, .rst_n, .start(cp_start), .busy(copy_busy), .idx(cp_idx)
  );

  pcr_store #(.RF_N(RF_N), .TBL_N(TBL_N), .NV_N(NV_N)) u_store (
    .clk, .rst_n, .exec_vld, .exec_op, .exec_argc, .exec_a0, .exec_a1,
    .exec_a2, .mw_dst_vld, .mw_addr_vld, .mw_data_vld, .mw_byte(in_data),
    .err_opc, .err_bank, .rd_fire, .rd_data, .cp_busy(copy_busy), .cp_idx,
    .cp_start, .pwm_duty, .pwm_top, .pwm_div, .hold_delay, .hold_at_attack,
    .note_on, .note_off, .attack_ticks, .err_status
  );

  // R10: both streams stall while the copy runs
  assert_busy_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    copy_busy |-> !in_ready && !rd_valid);
endmodule

// File: tb/tb_pcr_top.sv
`timescale 1ns/1ps
module tb_pcr_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_start = 0, in_stop = 0, rd_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, rd_valid, hold_at_attack, note_on, note_off, copy_busy;
  logic [7:0] rd_data, pwm_duty, pwm_top, pwm_div, err_status;
  logic [15:0] hold_delay, attack_ticks;
  int nvec = 0, nmis = 0;

  always #2.5 clk = ~clk;

  pcr_top dut (.*);

  // argc, a0, a1, a2, expected duty, top, div
  localparam int NV = 6;
  localparam logic [49:0] VEC [NV] = '{
    {2'd3, 8'd10,  8'd20,  8'd3,  8'd10,  8'd20,  8'd3},
    {2'd1, 8'd50,  8'd0,   8'd0,  8'd50,  8'd255, 8'd5},
    {2'd2, 8'd60,  8'd70,  8'd0,  8'd60,  8'd70,  8'd5},
    {2'd3, 8'd1,   8'd2,   8'd15, 8'd1,   8'd2,   8'd15},
    {2'd0, 8'd99,  8'd99,  8'd99, 8'd1,   8'd2,   8'd15},
    {2'd3, 8'd127, 8'd255, 8'd5,  8'd127, 8'd255, 8'd5}
  };

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start_pkt();
    @(negedge clk) in_start = 1;
    @(negedge clk) in_start = 0;
  endtask

  task automatic byte_in(logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk) in_valid = 0;
  endtask

  task automatic stop_pkt();
    @(negedge clk) in_stop = 1;
    @(negedge clk) in_stop = 0;
  endtask

  task automatic pkt3(logic [7:0] op, int n, logic [7:0] x, logic [7:0] y, logic [7:0] z);
    start_pkt();
    byte_in(op);
    if (n > 0) byte_in(x);
    if (n > 1) byte_in(y);
    if (n > 2) byte_in(z);
    stop_pkt();
  endtask

  task automatic rd_get(output logic [7:0] b);
    @(negedge clk);
    while (!rd_valid) @(negedge clk);
    b = rd_data; rd_ready = 1;
    @(negedge clk) rd_ready = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    nvec++; nmis++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0] b;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 duty", pwm_duty, 127); chk("R1 top", pwm_top, 255);
    chk("R1 div", pwm_div, 5); chk("R1 delay", hold_delay, 0);
    chk("R1 flags", hold_at_attack, 0); chk("R1 err", err_status, 0);
    chk("R1 busy", copy_busy, 0);
    rd_get(b); chk("R1 read rf[0]", b, 0);

    // R2 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      pkt3(8'd0, int'(v[49:48]), v[47:40], v[39:32], v[31:24]);
      chk("R2 duty", pwm_duty, v[23:16]);
      chk("R2 top", pwm_top, v[15:8]);
      chk("R2 div", pwm_div, v[7:0]);
    end

    // R6 burst write with address into velocity table
    start_pkt(); byte_in(8'h81); byte_in(8'd10);
    stop_pkt();
    start_pkt(); byte_in(8'd5); byte_in(8'h81); byte_in(8'd10);
    byte_in(8'h33); byte_in(8'h44); stop_pkt();
    // R6 no-address form continues at write pointer 12
    start_pkt(); byte_in(8'd5); byte_in(8'h01); byte_in(8'h55); stop_pkt();
    chk("R11 stray-start packet left err", err_status, 1);
    pkt3(8'd5, 3, 8'h80, 8'd15, 8'h00);
    chk("R9 err cleared by write", err_status, 0);
    // R5 read back with auto increment
    pkt3(8'd4, 2, 8'd1, 8'd10, 0);
    rd_get(b); chk("R5 vel[10]", b, 8'h33);
    rd_get(b); chk("R5 vel[11]", b, 8'h44);
    rd_get(b); chk("R6 vel[12]", b, 8'h55);

    // R3 velocity onset
    pkt3(8'd1, 1, 8'd10, 0, 0);
    chk("R3 note_on", note_on, 1); chk("R3 ticks", attack_ticks, 16'h0033);
    @(negedge clk); chk("R3 pulse one cycle", note_on, 0);
    pkt3(8'd1, 1, 8'h8B, 0, 0);
    chk("R3 vel low bits", attack_ticks, 16'h0044);
    pkt3(8'd2, 2, 8'h12, 8'h34, 0);
    chk("R3 ticks note_on", note_on, 1); chk("R3 tick pair", attack_ticks, 16'h1234);
    pkt3(8'd3, 0, 0, 0, 0);
    chk("R4 note_off", note_off, 1); chk("R4 no note_on", note_on, 0);

    // R7 hold delay forms
    pkt3(8'd7, 2, 8'hAB, 8'hCD, 0); chk("R7 two bytes", hold_delay, 16'hABCD);
    pkt3(8'd7, 1, 8'h12, 0, 0);     chk("R7 one byte", hold_delay, 16'h1200);
    pkt3(8'd7, 0, 0, 0, 0);         chk("R7 none", hold_delay, 0);

    // R8 flags
    pkt3(8'd8, 1, 8'h01, 0, 0); chk("R8 hold_at_attack", hold_at_attack, 1);

    // R9 errors
    pkt3(8'd9, 1, 8'd5, 0, 0);
    chk("R9 bad opcode", err_status, 1); chk("R9 ignored", pwm_duty, 127);
    pkt3(8'd4, 2, 8'd3, 8'd0, 0); chk("R9 bad source", err_status, 3);
    pkt3(8'd5, 3, 8'h80, 8'd15, 8'h00); chk("R9 clear", err_status, 0);
    pkt3(8'd5, 2, 8'h83, 8'h77, 0); chk("R9 bad bank", err_status, 2);
    pkt3(8'd5, 3, 8'h80, 8'd15, 8'h00);

    // R13 register file reads
    pkt3(8'd4, 2, 8'd0, 8'd11, 0);
    rd_get(b); chk("R13 duty reg", b, 127);
    rd_get(b); chk("R13 top reg", b, 255);
    pkt3(8'd4, 2, 8'd0, 8'd20, 0);
    rd_get(b); chk("R13 out of range", b, 0);

    // R11 framing
    byte_in(8'd0); byte_in(8'h10);
    chk("R11 stray bytes", pwm_duty, 127);
    start_pkt(); byte_in(8'd0); byte_in(8'h20);
    start_pkt(); byte_in(8'd8); byte_in(8'h00);
    @(negedge clk) in_stop = 1;
    #1 chk("R11 ready low at stop", in_ready, 0);
    @(negedge clk) in_stop = 0;
    chk("R11 abandoned packet", pwm_duty, 127);
    chk("R11 restarted packet", hold_at_attack, 0);

    // R12 read transfer meets pointer reload
    pkt3(8'd4, 2, 8'd1, 8'd11, 0);
    start_pkt(); byte_in(8'd4); byte_in(8'd1); byte_in(8'd10);
    @(negedge clk) in_stop = 1; rd_ready = 1; b = rd_data;
    @(negedge clk) in_stop = 0; rd_ready = 0;
    chk("R12 old pointer byte", b, 8'h44);
    rd_get(b); chk("R12 reload wins", b, 8'h33);

    // R10 copy
    pkt3(8'd6, 0, 0, 0, 0);
    chk("R10 busy", copy_busy, 1); chk("R10 in_ready", in_ready, 0);
    chk("R10 rd_valid", rd_valid, 0);
    cnt = 0;
    while (copy_busy && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R10 busy length", cnt, 128);
    pkt3(8'd4, 2, 8'd2, 8'd10, 0);
    rd_get(b); chk("R10 nv[10]", b, 8'h33);
    rd_get(b); chk("R10 nv[11]", b, 8'h44);
    rd_get(b); chk("R10 nv[12]", b, 8'h55);
    summary();
  end
endmodule